// File: doc/BRIEF.md
# Ling Carry-Tree Adder with Mixed Valency

This block adds two 32-bit operands and a carry-in in one combinational path, producing a 32-bit sum and a carry-out. Rather than passing true carries through its prefix tree, it passes Ling pseudo-carries. A pseudo-carry at bit i collapses a generate term and the transmit of the bit below into a single node. The true carry is formed only at the sum stage, as transmit times pseudo-carry, and this drops one AND input from every product term of the carry expansion.

The tree does not treat both halves alike. The lower twelve bits form bit pairs that are gathered three at a time, giving two groups. The upper twenty bits form bit pairs that are gathered five at a time, also giving two groups. Each half joins its two groups in a radix-2 step, and a final radix-2 step joins the two halves. Every bit position also receives its own prefix by fan-out from these group nodes, so that each sum bit sees the carry from the bit directly below it.

The block is meant to sit in a datapath where an add has to fit inside one cycle. The valencies of the two halves are parameters, and the operand width follows from them.

Top module: `ling_adder`

## Requirements
- R1: For every operand pair and carry-in, `sum` equals (a + b + cin) modulo 2^32.
- R2: `cout` equals bit 32 of the 33-bit value a + b + cin.
- R3: a = 0xFFFFFFFF, b = 0, cin = 1 gives sum 0 and cout 1.
- R4: With both operands zero, sum equals cin (bit 0 only) and cout is 0.
- R5: A carry chain that starts in bits 0–11 and crosses into bit 12 (for example 0x00000FFF + 1) is resolved correctly, and likewise a chain that starts below bit 12 and runs to the top.
- R6: Carries that cross the group boundaries at bit 6 and at bit 22 (for example 0x0000003F + 1 and 0x003FFFFF + 1) are resolved correctly.
- R7: When every bit transmits but no bit generates (b = ~a), the sum is all ones with cout 0 for cin = 0, and all zeros with cout 1 for cin = 1.
- R8: Alternating patterns (0xAAAAAAAA, 0x55555555 and their combinations, with both carry-in values) give the arithmetic sum.
- R9: A single carry generated at any bit k (a = b = 2^k) appears at bit k+1 and at no other bit. For k = 31 it appears only as cout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 32 | Low 32 bits of a + b + cin |
| cout | output | 1 | Carry out of bit 31 |

## Verification
On every input change, the assertions check three things. The 33-bit result must match the arithmetic sum. Each carry recovered from a pseudo-carry must satisfy the true-carry recurrence bit by bit. The flat group term of each valency-3 and valency-5 node, and each radix-2 merge, must agree with the fan-out prefix at its top bit. Whether particular chains are actually driven across the bit-6, bit-12 and bit-22 seams, and whether full propagate and walking-generate cases are reached, is shown only by the bench's directed scenarios and its large random run.

// File: rtl/ling_pkg.sv
package ling_pkg;

    // One prefix node in Ling form: gen is the (pseudo) generate,
    // xmit is the transmit taken from one bit below.
    typedef struct packed {
        logic gen;
        logic xmit;
    } lnode_t;

    // Prefix operator: upper span over lower span.
    function automatic lnode_t lmerge(input lnode_t hi, input lnode_t lo);
        lnode_t r;
        r.gen  = hi.gen | (hi.xmit & lo.gen);
        r.xmit = hi.xmit & lo.xmit;
        return r;
    endfunction

endpackage

// File: rtl/ling_bitgen.sv
module ling_bitgen
    import ling_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           cin,
    output logic [W-1:0]   gen_o,
    output logic [W-1:0]   xmit_o,
    output logic [W-1:0]   half_o,
    output lnode_t [W-1:0] node_o
);

    always_comb begin
        gen_o  = a & b;
        xmit_o = a | b;
        half_o = a ^ b;
    end

    // Node i carries g_i and t_{i-1}; the carry-in folds into bit 0
    // with an implied transmit of one below it.
    generate
        for (genvar i = 0; i < W; i++) begin : g_node
            if (i == 0) begin : g_lsb
                assign node_o[i].gen  = gen_o[0] | cin;
                assign node_o[i].xmit = 1'b0;
            end else begin : g_rest
                assign node_o[i].gen  = gen_o[i];
                assign node_o[i].xmit = xmit_o[i-1];
            end
        end
    endgenerate

    always_comb begin
        // R1
        gen_in_xmit_chk: assert ((gen_o & ~xmit_o) == '0)
            else $error("generate without transmit");
        // R1
        half_split_chk: assert (half_o == (xmit_o & ~gen_o))
            else $error("half-sum inconsistent with generate/transmit");
    end

endmodule

// File: rtl/ling_group.sv
module ling_group
    import ling_pkg::*;
#(
    parameter int VAL = 3
) (
    input  lnode_t [2*VAL-1:0] node_i,
    output lnode_t [2*VAL-1:0] pre_o,
    output lnode_t             grp_o
);

    localparam int NB = 2 * VAL;

    lnode_t [VAL-1:0] pair_d;
    lnode_t [VAL-1:0] run_d;

    // Radix-2 first level: bit pairs.
    generate
        for (genvar k = 0; k < VAL; k++) begin : g_pair
            assign pair_d[k] = lmerge(node_i[2*k+1], node_i[2*k]);
        end
    endgenerate

    // Valency-VAL group node as one flat sum of products.
    always_comb begin
        logic tail;
        grp_o.gen  = 1'b0;
        grp_o.xmit = 1'b1;
        for (int k = 0; k < VAL; k++) begin
            tail = 1'b1;
            for (int j = k + 1; j < VAL; j++) tail = tail & pair_d[j].xmit;
            grp_o.gen  = grp_o.gen | (pair_d[k].gen & tail);
            grp_o.xmit = grp_o.xmit & pair_d[k].xmit;
        end
    end

    // Fan-out: prefix of every pair boundary from the group bottom.
    always_comb begin
        lnode_t acc;
        acc      = pair_d[0];
        run_d[0] = acc;
        for (int k = 1; k < VAL; k++) begin
            acc      = lmerge(pair_d[k], acc);
            run_d[k] = acc;
        end
    end

    generate
        for (genvar k = 0; k < VAL; k++) begin : g_bitpre
            assign pre_o[2*k+1] = run_d[k];
            if (k == 0) begin : g_first
                assign pre_o[0] = node_i[0];
            end else begin : g_other
                assign pre_o[2*k] = lmerge(node_i[2*k], run_d[k-1]);
            end
        end
    endgenerate

    always_comb begin
        // R6
        grp_top_chk: assert (grp_o == pre_o[NB-1])
            else $error("group node disagrees with fan-out prefix");
    end

endmodule

// File: rtl/ling_half.sv
module ling_half
    import ling_pkg::*;
#(
    parameter int VAL = 3
) (
    input  lnode_t [4*VAL-1:0] node_i,
    output lnode_t [4*VAL-1:0] pre_o,
    output lnode_t             span_o
);

    localparam int GW = 2 * VAL;
    localparam int HW = 2 * GW;

    lnode_t [GW-1:0] lo_pre;
    lnode_t [GW-1:0] hi_pre;
    lnode_t          lo_grp;
    lnode_t          hi_grp;

    ling_group #(.VAL(VAL)) u_lo (
        .node_i (node_i[GW-1:0]),
        .pre_o  (lo_pre),
        .grp_o  (lo_grp)
    );

    ling_group #(.VAL(VAL)) u_hi (
        .node_i (node_i[HW-1:GW]),
        .pre_o  (hi_pre),
        .grp_o  (hi_grp)
    );

    // Radix-2 join of the two groups.
    assign span_o = lmerge(hi_grp, lo_grp);

    generate
        for (genvar j = 0; j < GW; j++) begin : g_fan
            assign pre_o[j]      = lo_pre[j];
            assign pre_o[GW + j] = lmerge(hi_pre[j], lo_grp);
        end
    endgenerate

    always_comb begin
        // R5
        span_top_chk: assert (span_o == pre_o[HW-1])
            else $error("half span disagrees with top-bit prefix");
    end

endmodule

// File: rtl/ling_adder.sv
module ling_adder
    import ling_pkg::*;
#(
    parameter  int LO_VAL = 3,
    parameter  int HI_VAL = 5,
    localparam int W      = 4 * (LO_VAL + HI_VAL)
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);

    localparam int LO_W = 4 * LO_VAL;
    localparam int HI_W = 4 * HI_VAL;

    logic   [W-1:0]    gen_w;
    logic   [W-1:0]    xmit_w;
    logic   [W-1:0]    half_w;
    lnode_t [W-1:0]    node_w;
    lnode_t [LO_W-1:0] lo_pre;
    lnode_t [HI_W-1:0] hi_pre;
    lnode_t            lo_span;
    lnode_t            hi_span;
    lnode_t            full_span;
    logic   [W-1:0]    pseudo_d;
    logic   [W-1:0]    carry_d;

    ling_bitgen #(.W(W)) u_bits (
        .a      (a),
        .b      (b),
        .cin    (cin),
        .gen_o  (gen_w),
        .xmit_o (xmit_w),
        .half_o (half_w),
        .node_o (node_w)
    );

    ling_half #(.VAL(LO_VAL)) u_lo_half (
        .node_i (node_w[LO_W-1:0]),
        .pre_o  (lo_pre),
        .span_o (lo_span)
    );

    ling_half #(.VAL(HI_VAL)) u_hi_half (
        .node_i (node_w[W-1:LO_W]),
        .pre_o  (hi_pre),
        .span_o (hi_span)
    );

    // Final radix-2 join of the two halves: full-width span.
    assign full_span = lmerge(hi_span, lo_span);

    generate
        for (genvar i = 0; i < LO_W; i++) begin : g_lo_h
            assign pseudo_d[i] = lo_pre[i].gen;
        end
        for (genvar i = 0; i < HI_W; i++) begin : g_hi_h
            lnode_t joined;
            assign joined              = lmerge(hi_pre[i], lo_span);
            assign pseudo_d[LO_W + i]  = joined.gen;
        end
    endgenerate

    // True carries recovered only where sums need them.
    assign carry_d = xmit_w & pseudo_d;

    generate
        for (genvar i = 0; i < W; i++) begin : g_sum
            if (i == 0) begin : g_s0
                assign sum[0] = half_w[0] ^ cin;
            end else begin : g_sn
                assign sum[i] = half_w[i] ^ carry_d[i-1];
            end
        end
    endgenerate

    assign cout = xmit_w[W-1] & full_span.gen;

    always_comb begin
        logic [W:0] ref_sum;
        logic       prev;
        ref_sum = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        // R1
        sum_value_chk: assert (sum == ref_sum[W-1:0])
            else $error("sum differs from arithmetic result");
        // R2
        carry_out_chk: assert (cout == ref_sum[W])
            else $error("carry-out differs from arithmetic result");
        // R2
        full_span_chk: assert (full_span.gen == pseudo_d[W-1])
            else $error("full-width span disagrees with top pseudo-carry");
        // R9
        prev = cin;
        for (int i = 0; i < W; i++) begin
            carry_recur_chk: assert (carry_d[i] == (gen_w[i] | (xmit_w[i] & prev)))
                else $error("recovered carry breaks recurrence at bit %0d", i);
            prev = carry_d[i];
        end
    end

endmodule

// File: tb/ling_adder_tb.sv
module ling_adder_tb;

    logic        clk;
    logic        rst;
    logic [31:0] a;
    logic [31:0] b;
    logic        cin;
    logic [31:0] sum;
    logic        cout;
    int          n_cmp;
    int          n_bad;
    bit          done;

    ling_adder u_dut (
        .a    (a),
        .b    (b),
        .cin  (cin),
        .sum  (sum),
        .cout (cout)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic apply(input logic [31:0] av, input logic [31:0] bv,
                         input logic ci, input string tag);
        logic [32:0] expv;
        @(posedge clk);
        a   = av;
        b   = bv;
        cin = ci;
        @(negedge clk);
        expv = {1'b0, av} + {1'b0, bv} + {32'd0, ci};
        n_cmp++;
        if ({cout, sum} !== expv) begin
            n_bad++;
            $display("FAIL %s: a=%h b=%h cin=%0d actual cout/sum=%0d/%h expected %0d/%h",
                     tag, av, bv, ci, cout, sum, expv[32], expv[31:0]);
        end
    endtask

    task automatic expect_fixed(input logic [31:0] av, input logic [31:0] bv,
                                input logic ci, input logic [31:0] es,
                                input logic ec, input string tag);
        @(posedge clk);
        a   = av;
        b   = bv;
        cin = ci;
        @(negedge clk);
        n_cmp++;
        if (sum !== es || cout !== ec) begin
            n_bad++;
            $display("FAIL %s: actual cout/sum=%0d/%h expected %0d/%h",
                     tag, cout, sum, ec, es);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        n_cmp = 0;
        n_bad = 0;
        done  = 1'b0;
        rst   = 1'b1;
        a     = '0;
        b     = '0;
        cin   = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // Reset state: zero inputs give zero outputs (R4).
        n_cmp++;
        if (sum !== 32'd0 || cout !== 1'b0) begin
            n_bad++;
            $display("FAIL R4 reset: actual %0d/%h expected 0/00000000", cout, sum);
        end
        rst = 1'b0;

        // R4: zero operands.
        expect_fixed(32'd0, 32'd0, 1'b0, 32'd0, 1'b0, "R4 zero cin0");
        expect_fixed(32'd0, 32'd0, 1'b1, 32'd1, 1'b0, "R4 zero cin1");

        // R3: all ones plus carry-in.
        expect_fixed(32'hFFFF_FFFF, 32'd0, 1'b1, 32'd0, 1'b1, "R3 ones+cin");
        expect_fixed(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 32'hFFFF_FFFF, 1'b1, "R3 ones+ones+cin");

        // R5: chains across bit 11/12.
        expect_fixed(32'h0000_0FFF, 32'd1, 1'b0, 32'h0000_1000, 1'b0, "R5 0FFF+1");
        expect_fixed(32'h0000_0FFF, 32'd0, 1'b1, 32'h0000_1000, 1'b0, "R5 0FFF+cin");
        expect_fixed(32'hFFFF_F800, 32'h0000_0800, 1'b0, 32'd0, 1'b1, "R5 bit11 to top");
        apply(32'h0000_0C00, 32'h0000_0C00, 1'b0, "R5 gen at 10/11");

        // R6: chains across group seams at bit 6 and bit 22.
        expect_fixed(32'h0000_003F, 32'd1, 1'b0, 32'h0000_0040, 1'b0, "R6 seam6");
        expect_fixed(32'h003F_FFFF, 32'd1, 1'b0, 32'h0040_0000, 1'b0, "R6 seam22");
        apply(32'h0030_0000, 32'h0010_0000, 1'b1, "R6 seam22 gen");

        // R7: pure propagate.
        expect_fixed(32'h1234_5678, ~32'h1234_5678, 1'b0, 32'hFFFF_FFFF, 1'b0, "R7 prop cin0");
        expect_fixed(32'h1234_5678, ~32'h1234_5678, 1'b1, 32'd0, 1'b1, "R7 prop cin1");

        // R8: alternating patterns.
        for (int m = 0; m < 8; m++) begin
            apply((m & 1) ? 32'hAAAA_AAAA : 32'h5555_5555,
                  (m & 2) ? 32'hAAAA_AAAA : 32'h5555_5555,
                  logic'(m >> 2), "R8 alternating");
        end

        // R9: walking single generate.
        for (int k = 0; k < 32; k++) begin
            expect_fixed(32'd1 << k, 32'd1 << k, 1'b0,
                         (k == 31) ? 32'd0 : (32'd1 << (k + 1)),
                         (k == 31) ? 1'b1 : 1'b0, "R9 walking gen");
        end

        // R1 R2: random vectors against the behavioural sum.
        for (int n = 0; n < 100000; n++) begin
            logic [31:0] ra;
            logic [31:0] rb;
            ra = $urandom;
            rb = $urandom;
            if (n % 16 == 0) rb = ~ra ^ (32'd1 << (n % 32));
            apply(ra, rb, logic'($urandom & 1), "R1 R2 random");
        end

        done = 1'b1;
        report();
        $finish;
    end

endmodule